// File: doc/BRIEF.md
# Circular-Flag Queue Lock Manager

This block arbitrates one shared resource among a set of requesting ports in strict arrival order. A port that asks for the lock draws a ticket from a tail counter that reads and advances in one step. It then waits until the flag slot chosen by that ticket holds the ownership token. Slots are picked by the ticket modulo the port count.

A release moves the token forward by one slot. The next ticket holder therefore wins without contending for a shared lock word. Each waiter watches only its own slot. When several ports ask in the same cycle, lower port indices draw earlier tickets. The counter then advances by the number of tickets it handed out.

Grants are registered outputs. A port keeps its ticket in a local register until it releases the lock. The port count is a power of two, and the tail counter wraps at that count.

Top module: `aql_lock`

## Requirements
- R1: After reset the token sits in slot 0, the tail counter is 0 and every grant is low. As a result, the first port to request after reset is granted.
- R2: A request from an idle port takes the current tail value as its ticket, and the tail advances by one. With no accepted request, the tail is unchanged.
- R3: Requests from several idle ports in one cycle receive consecutive tickets in ascending port index order. The tail advances by the number of such requests.
- R4: A port's grant rises only while the slot at its ticket holds the token. If the request is sampled at clock edge k and its slot already holds the token, the grant is high after edge k+1.
- R5: An unlock from the granted port drops its grant after that same edge. The token moves to slot (ticket+1) mod P, and the port owning that ticket is granted after the following edge.
- R6: An unlock from a port that is not granted is ignored. The grants, the token position and the port's ticket stay unchanged.
- R7: A request from a port that already holds a ticket is ignored. The port gets no second ticket and the tail does not advance.
- R8: Tickets and the token both wrap modulo P. A release from slot P-1 hands the token to slot 0.
- R9: At most one grant is high in any cycle, and exactly one slot holds the token.
- R10: A grant stays high on every cycle until its port unlocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lock_req | input | NPORT | Per-port request for a ticket |
| unlock_req | input | NPORT | Per-port release of the held lock |
| grant | output | NPORT | Registered per-port ownership indication |

## Verification
Several properties are checked on every cycle. Exactly one slot holds the token, and at most one grant is high. A held grant persists until its owner releases. A rejected release leaves the port waiting. A waiting port's ticket and an idle tail counter stay stable.

Other behaviours show only in the bench's scenarios, which a behavioural reference model follows cycle by cycle:
- the ascending-index order of same-cycle tickets,
- the two-edge request-to-grant latency,
- the handoff to the correct successor,
- the wrap of tickets past slot P-1.

// File: rtl/aql_pkg.sv
package aql_pkg;
  typedef enum logic {
    SLOT_IDLE  = 1'b0,
    SLOT_OWNER = 1'b1
  } slot_state_e;
endpackage

// File: rtl/aql_ticket.sv
module aql_ticket #(
  parameter int NPORT = 4,
  parameter int SW    = $clog2(NPORT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT-1:0]          take,
  output logic [NPORT-1:0][SW-1:0]  offer
);
  logic [SW-1:0] tail_q;
  logic [SW-1:0] tail_n;

  // ascending-index prefix count gives each taker its ticket
  always_comb begin
    logic [SW-1:0] run;
    run = tail_q;
    for (int i = 0; i < NPORT; i++) begin
      offer[i] = run;
      if (take[i]) run = run + 1'b1;
    end
    tail_n = run;
  end

  always_ff @(posedge clk) begin
    if (rst) tail_q <= '0;
    else     tail_q <= tail_n;
  end

  // R2 / R7: no accepted request leaves the tail alone
  a_r2_tail_idle: assert property (@(posedge clk) disable iff (rst)
    (take == '0) |=> $stable(tail_q));
endmodule

// File: rtl/aql_flags.sv
module aql_flags
  import aql_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int SW    = $clog2(NPORT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT-1:0]          pass,
  input  logic [NPORT-1:0][SW-1:0]  pass_slot,
  output logic [NPORT-1:0]          slot_owner
);
  slot_state_e slots [NPORT];
  logic [NPORT-1:0][SW-1:0] succ;

  generate
    for (genvar i = 0; i < NPORT; i++) begin : g_succ
      assign succ[i]       = SW'(pass_slot[i] + 1'b1);
      assign slot_owner[i] = (slots[i] == SLOT_OWNER);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NPORT; s++)
        slots[s] <= (s == 0) ? SLOT_OWNER : SLOT_IDLE;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (pass[i]) begin
          slots[pass_slot[i]] <= SLOT_IDLE;
          slots[succ[i]]      <= SLOT_OWNER;
        end
      end
    end
  end

  // R9: the token is never lost or duplicated
  a_r9_single_token: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_owner) == 1);
  // R6: slots move only on a valid release
  a_r6_slots_still: assert property (@(posedge clk) disable iff (rst)
    (pass == '0) |=> $stable(slot_owner));
endmodule

// File: rtl/aql_port.sv
module aql_port #(
  parameter int NPORT = 4,
  parameter int SW    = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             rel,
  input  logic [SW-1:0]    offer,
  input  logic [NPORT-1:0] slot_owner,
  output logic             take,
  output logic             pass,
  output logic [SW-1:0]    place,
  output logic             grant
);
  logic busy;

  assign take = req & ~busy;
  assign pass = rel & grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      grant <= 1'b0;
      place <= '0;
    end else begin
      if (take) begin
        busy  <= 1'b1;
        place <= offer;
      end
      if (pass) busy <= 1'b0;
      grant <= busy & slot_owner[place] & ~pass;
    end
  end

  // R10: ownership persists until released
  a_r10_grant_held: assert property (@(posedge clk) disable iff (rst)
    (grant && !rel) |=> grant);
  // R6: release while waiting is dropped
  a_r6_keep_waiting: assert property (@(posedge clk) disable iff (rst)
    (busy && !grant && rel) |=> busy);
  // R7: a held ticket never changes
  a_r7_ticket_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && !pass) |=> $stable(place));
  // R4: a grant only follows a waiting cycle
  a_r4_grant_after_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> $past(busy));
endmodule

// File: rtl/aql_lock.sv
module aql_lock #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] lock_req,
  input  logic [NPORT-1:0] unlock_req,
  output logic [NPORT-1:0] grant
);
  localparam int SW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0]         take;
  logic [NPORT-1:0]         pass;
  logic [NPORT-1:0]         slot_owner;
  logic [NPORT-1:0][SW-1:0] offer;
  logic [NPORT-1:0][SW-1:0] place;

  aql_ticket #(.NPORT(NPORT), .SW(SW)) u_ticket (
    .clk(clk), .rst(rst), .take(take), .offer(offer)
  );

  aql_flags #(.NPORT(NPORT), .SW(SW)) u_flags (
    .clk(clk), .rst(rst), .pass(pass), .pass_slot(place),
    .slot_owner(slot_owner)
  );

  generate
    for (genvar i = 0; i < NPORT; i++) begin : g_port
      aql_port #(.NPORT(NPORT), .SW(SW)) u_port (
        .clk(clk), .rst(rst),
        .req(lock_req[i]), .rel(unlock_req[i]),
        .offer(offer[i]), .slot_owner(slot_owner),
        .take(take[i]), .pass(pass[i]),
        .place(place[i]), .grant(grant[i])
      );
    end
  endgenerate

  // R9: mutual exclusion at the ports
  a_r9_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: tb/sim_aql_lock.sv
module sim_aql_lock;
  localparam int P = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [P-1:0] lock_req = '0;
  logic [P-1:0] unlock_req = '0;
  logic [P-1:0] grant;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int  m_tail;
  bit  m_tok [P];
  int  m_place [P];
  bit  m_act [P];
  bit  m_grant [P];

  aql_lock #(.NPORT(P)) u0 (
    .clk(clk), .rst(rst), .lock_req(lock_req),
    .unlock_req(unlock_req), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [P-1:0] model_vec();
    logic [P-1:0] v;
    for (int i = 0; i < P; i++) v[i] = m_grant[i];
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_tail = 0;
      for (int s = 0; s < P; s++) begin
        m_tok[s] = (s == 0);
        m_act[s] = 0; m_place[s] = 0; m_grant[s] = 0;
      end
    end else begin
      bit rel_ok [P];
      bit g_n [P];
      bit acc [P];
      for (int i = 0; i < P; i++) begin
        rel_ok[i] = unlock_req[i] && m_grant[i];
        g_n[i]    = m_act[i] && m_tok[m_place[i]] && !rel_ok[i];
        acc[i]    = lock_req[i] && !m_act[i];
      end
      for (int i = 0; i < P; i++) begin
        if (rel_ok[i]) begin
          m_tok[m_place[i]] = 0;
          m_tok[(m_place[i] + 1) % P] = 1;
          m_act[i] = 0;
        end
      end
      for (int i = 0; i < P; i++) begin
        if (acc[i]) begin
          m_place[i] = m_tail;
          m_act[i] = 1;
          m_tail = (m_tail + 1) % P;
        end
        m_grant[i] = g_n[i];
      end
    end
  end

  task automatic check_vec(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s grant=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [P-1:0] r, input logic [P-1:0] u, input string tag);
    lock_req = r;
    unlock_req = u;
    @(negedge clk);
    lock_req = '0;
    unlock_req = '0;
    check_vec(tag, grant, model_vec());
    checks++;
    if ($countones(grant) > 1) begin
      errors++;
      $display("FAIL R9 grant=%b expected at most one bit", grant);
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog grant=%b expected run to finish", grant);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_vec("R1", grant, 4'b0000);
    step('0, '0, "R1");
    // R1/R2: port2 takes ticket 0, granted after the following edge
    step(4'b0100, '0, "R2");
    check_vec("R4", grant, 4'b0000);
    step('0, '0, "R4");
    check_vec("R1", grant, 4'b0100);
    // R10: held while no unlock
    step('0, '0, "R10");
    step('0, '0, "R10");
    check_vec("R10", grant, 4'b0100);
    // R5: release moves token to slot 1
    step('0, 4'b0100, "R5");
    check_vec("R5", grant, 4'b0000);
    // R3: ports 0,1,3 same cycle -> tickets 1,2,3
    step(4'b1011, '0, "R3");
    step('0, '0, "R3");
    check_vec("R3", grant, 4'b0001);
    // R6: unlock from waiting ports ignored
    step('0, 4'b1010, "R6");
    step('0, '0, "R6");
    check_vec("R6", grant, 4'b0001);
    // R7: port1 requests again while waiting
    step(4'b0010, '0, "R7");
    // R8: port2 takes ticket 0 after wrap
    step(4'b0100, '0, "R8");
    step('0, 4'b0001, "R5");
    step('0, '0, "R5");
    check_vec("R3", grant, 4'b0010);
    step('0, 4'b0010, "R5");
    step('0, '0, "R5");
    check_vec("R3", grant, 4'b1000);
    step('0, 4'b1000, "R8");
    step('0, '0, "R8");
    check_vec("R8", grant, 4'b0100);
    step('0, 4'b0100, "R8");
    step('0, '0, "R8");
    check_vec("R8", grant, 4'b0000);
    // mixed traffic checked against the model every cycle
    lf = 8'h5a;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[3:0], lf[7:4] | grant, "R4");
    end
    repeat (8) step('0, grant, "R5");
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule